// File: doc/BRIEF.md
# Flow-Control Status Framer with In-Band Calendar Selection

This block produces the two-bit-per-cycle flow-control status stream that a packet receive interface sends back to its transmitter. Every frame opens with the framing word '11'. An optional selection word follows it and names which of two calendars the frame uses. Then come the per-port status entries, read slot by slot from the chosen calendar through a lookup port. A two-bit diagonal parity word closes the frame.

Each calendar has its own slot count and repetition count. A frame sends slots 0 to length-1 in order, repeated the programmed number of times. Configuration is taken only at the start of a frame, so software may change it at any time without corrupting a frame in flight. A separate bit decides whether the selection word counts towards the parity.

Top module: `stsFramer`

## Requirements
- R1: Every frame begins with the word 2'b11 on `statOut`, and `frameStart` is 1 in exactly that cycle and 0 in all others.
- R2: When `selInsertEn` is 1 at frame start, the word right after the framing word is a calendar selection word.
- R3: The selection word is 2'b01 when calendar 0 is chosen (`calReq`=0) and 2'b10 when calendar 1 is chosen (`calReq`=1).
- R4: When `selInsertEn` is 0 at frame start, no selection word is sent and calendar 0 is used whatever `calReq` says.
- R5: A frame carries length × repetitions entries, slots 0 to length-1 in rising order once per repetition. `slotCal` and `slotIdx` present the slot, and `slotStatus` is taken in the same cycle. A length of 0 counts as 1, a length above MAX_LEN counts as MAX_LEN, and a repetition count of 0 counts as 1.
- R6: `calReq`, `selInsertEn`, `dipCoversSel` and the four length and repetition inputs are sampled only in the cycle that issues the framing word. Changes made during a frame have no effect on that frame.
- R7: A lookup result of 2'b11 is sent as 2'b10. Other values are sent unchanged.
- R8: The last word of every frame is the parity word. The accumulator is cleared at framing. For each covered word w it becomes {acc[0], acc[1]} ^ w. The word sent is ~acc. Every status entry is covered.
- R9: The selection word is covered by the parity when `dipCoversSel` was 1 at frame start, and left out when it was 0.
- R10: During reset and while not enabled, `statOut` is 2'b11 with `frameStart` 0. Raising `enable` starts a fresh frame. Dropping `enable` lets the current frame finish, and continuous '11' follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run frames; checked at frame boundaries |
| selInsertEn | input | 1 | Insert the calendar selection word |
| calReq | input | 1 | Requested calendar (0 or 1) |
| dipCoversSel | input | 1 | Include the selection word in the parity |
| cal0Len | input | $clog2(MAX_LEN+1) | Slot count of calendar 0 |
| cal0Rep | input | REP_W | Repetition count of calendar 0 |
| cal1Len | input | $clog2(MAX_LEN+1) | Slot count of calendar 1 |
| cal1Rep | input | REP_W | Repetition count of calendar 1 |
| slotCal | output | 1 | Calendar of the slot being looked up |
| slotIdx | output | $clog2(MAX_LEN) | Index of the slot being looked up |
| slotStatus | input | 2 | Status returned for the presented slot |
| statOut | output | 2 | Status channel word |
| frameStart | output | 1 | Marks the framing word of each frame |

## Verification
The bench builds the block with MAX_LEN=8 and REP_W=2. Frames therefore stay under forty words, so hundreds of them fit in a short run. The four-bit length inputs can then exceed MAX_LEN and exercise the clamp, and repetition counts of 0 to 3 cover both the zero case and multiple passes. With only eight slots per table, the directed cases hit the '11' substitution on every slot and the calendar-1 selection word with and without parity coverage. The random frames change configuration in the middle of a frame to test R6.

// File: rtl/stsFramerPkg.sv
package stsFramerPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_SEL,
    ST_ENTRY,
    ST_DIP
  } stState_e;

  // Strobes from control to datapath for the word issued next edge.
  typedef struct packed {
    logic sendFrame;
    logic sendSel;
    logic sendEntry;
    logic sendDip;
    logic calSel;
    logic dipCoverSel;
  } strobe_t;

  localparam logic [1:0] WORD_FRAME = 2'b11;
  localparam logic [1:0] WORD_SAT   = 2'b10;
  localparam logic [1:0] SEL_CAL0   = 2'b01;
  localparam logic [1:0] SEL_CAL1   = 2'b10;

  // Diagonal parity step: rotate accumulator one place, fold in word.
  function automatic logic [1:0] dipStep(logic [1:0] acc, logic [1:0] w);
    return {acc[0], acc[1]} ^ w;
  endfunction

endpackage

// File: rtl/stsFramerCtrl.sv
module stsFramerCtrl
  import stsFramerPkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int REP_W   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             selInsertEn,
  input  logic             calReq,
  input  logic             dipCoversSel,
  input  logic [LEN_W-1:0] cal0Len,
  input  logic [REP_W-1:0] cal0Rep,
  input  logic [LEN_W-1:0] cal1Len,
  input  logic [REP_W-1:0] cal1Rep,
  output logic             slotCal,
  output logic [IDX_W-1:0] slotIdx,
  output strobe_t          stb
);

  stState_e state, stateNxt;
  logic curCal, curCov;
  logic [IDX_W-1:0] idx, lastIdx;
  logic [REP_W-1:0] rep, lastRep;
  logic reqCal, entryDone;

  // Without insertion the far end cannot know a switch, so stay on calendar 0.
  assign reqCal = selInsertEn & calReq;
  assign entryDone = (idx == lastIdx) && (rep == lastRep);

  function automatic logic [IDX_W-1:0] lastSlot(logic [LEN_W-1:0] len);
    if (len == '0) return '0;
    if (len > LEN_W'(MAX_LEN)) return IDX_W'(MAX_LEN - 1);
    return IDX_W'(len - 1'b1);
  endfunction

  function automatic logic [REP_W-1:0] lastRound(logic [REP_W-1:0] r);
    if (r == '0) return '0;
    return r - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curCal  <= 1'b0;
      curCov  <= 1'b0;
      idx     <= '0;
      rep     <= '0;
      lastIdx <= '0;
      lastRep <= '0;
    end else begin
      state <= stateNxt;
      case (state)
        ST_FRAME: begin
          curCal  <= reqCal;
          curCov  <= dipCoversSel;
          lastIdx <= lastSlot(reqCal ? cal1Len : cal0Len);
          lastRep <= lastRound(reqCal ? cal1Rep : cal0Rep);
          idx     <= '0;
          rep     <= '0;
        end
        ST_ENTRY: begin
          if (idx == lastIdx) begin
            idx <= '0;
            rep <= rep + 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  stateNxt = enable ? ST_FRAME : ST_IDLE;
      ST_FRAME: stateNxt = selInsertEn ? ST_SEL : ST_ENTRY;
      ST_SEL:   stateNxt = ST_ENTRY;
      ST_ENTRY: stateNxt = entryDone ? ST_DIP : ST_ENTRY;
      ST_DIP:   stateNxt = enable ? ST_FRAME : ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    stb             = '0;
    stb.sendFrame   = (state == ST_FRAME);
    stb.sendSel     = (state == ST_SEL);
    stb.sendEntry   = (state == ST_ENTRY);
    stb.sendDip     = (state == ST_DIP);
    stb.calSel      = curCal;
    stb.dipCoverSel = curCov;
  end

  assign slotCal = curCal;
  assign slotIdx = idx;

endmodule

// File: rtl/stsFramerPath.sv
module stsFramerPath
  import stsFramerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [1:0] slotStatus,
  output logic [1:0] statOut,
  output logic       frameStart
);

  logic [1:0] dipAcc, entryWord, selWord;

  // '11' is reserved for framing; report such a slot as satisfied.
  assign entryWord = (slotStatus == WORD_FRAME) ? WORD_SAT : slotStatus;
  assign selWord   = stb.calSel ? SEL_CAL1 : SEL_CAL0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statOut    <= WORD_FRAME;
      frameStart <= 1'b0;
      dipAcc     <= '0;
    end else begin
      frameStart <= stb.sendFrame;
      if (stb.sendFrame) begin
        statOut <= WORD_FRAME;
        dipAcc  <= '0;
      end else if (stb.sendSel) begin
        statOut <= selWord;
        if (stb.dipCoverSel) dipAcc <= dipStep(dipAcc, selWord);
      end else if (stb.sendEntry) begin
        statOut <= entryWord;
        dipAcc  <= dipStep(dipAcc, entryWord);
      end else if (stb.sendDip) begin
        statOut <= ~dipAcc;
      end else begin
        statOut <= WORD_FRAME;
      end
    end
  end

endmodule

// File: rtl/stsFramer.sv
module stsFramer
  import stsFramerPkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int REP_W   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             selInsertEn,
  input  logic             calReq,
  input  logic             dipCoversSel,
  input  logic [LEN_W-1:0] cal0Len,
  input  logic [REP_W-1:0] cal0Rep,
  input  logic [LEN_W-1:0] cal1Len,
  input  logic [REP_W-1:0] cal1Rep,
  output logic             slotCal,
  output logic [IDX_W-1:0] slotIdx,
  input  logic [1:0]       slotStatus,
  output logic [1:0]       statOut,
  output logic             frameStart
);

  strobe_t stb;

  stsFramerCtrl #(.MAX_LEN(MAX_LEN), .REP_W(REP_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .selInsertEn  (selInsertEn),
    .calReq       (calReq),
    .dipCoversSel (dipCoversSel),
    .cal0Len      (cal0Len),
    .cal0Rep      (cal0Rep),
    .cal1Len      (cal1Len),
    .cal1Rep      (cal1Rep),
    .slotCal      (slotCal),
    .slotIdx      (slotIdx),
    .stb          (stb)
  );

  stsFramerPath i_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .slotStatus (slotStatus),
    .statOut    (statOut),
    .frameStart (frameStart)
  );

endmodule

// File: rtl/stsFramerChk.sv
module stsFramerChk
  import stsFramerPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input strobe_t    stb,
  input logic [1:0] statOut,
  input logic       frameStart,
  input logic       slotCal
);

  // R1: the marked word is always the framing pattern
  assert_frame_pattern_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> statOut == 2'b11);

  // R2: a selection word is only ever issued right after framing
  assert_sel_after_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.sendSel |-> $past(stb.sendFrame));

  // R3: the selection word carries the fixed code of the chosen calendar
  assert_sel_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.sendSel |=> statOut == ($past(stb.calSel) ? 2'b10 : 2'b01));

  // R6: the calendar cannot change between consecutive entries of a frame
  assert_cal_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sendEntry && $past(stb.sendEntry)) |-> $stable(slotCal));

  // R7: an entry word never imitates framing
  assert_entry_not_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.sendEntry |=> statOut != 2'b11);

endmodule

bind stsFramer stsFramerChk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stb        (stb),
  .statOut    (statOut),
  .frameStart (frameStart),
  .slotCal    (slotCal)
);

// File: tb/test_stsFramer.sv
module test_stsFramer;
  localparam int MAX_LEN = 8;
  localparam int REP_W   = 2;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(MAX_LEN);

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rstN, enable, selInsertEn, calReq, dipCoversSel;
  logic [LEN_W-1:0] cal0Len, cal1Len;
  logic [REP_W-1:0] cal0Rep, cal1Rep;
  logic slotCal;
  logic [IDX_W-1:0] slotIdx;
  logic [1:0] slotStatus, statOut;
  logic frameStart;

  logic [1:0] tbl0 [MAX_LEN];
  logic [1:0] tbl1 [MAX_LEN];
  assign slotStatus = slotCal ? tbl1[slotIdx] : tbl0[slotIdx];

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  stsFramer #(.MAX_LEN(MAX_LEN), .REP_W(REP_W)) i_stsFramer (
    .clk(clk), .rstN(rstN), .enable(enable), .selInsertEn(selInsertEn),
    .calReq(calReq), .dipCoversSel(dipCoversSel),
    .cal0Len(cal0Len), .cal0Rep(cal0Rep), .cal1Len(cal1Len), .cal1Rep(cal1Rep),
    .slotCal(slotCal), .slotIdx(slotIdx), .slotStatus(slotStatus),
    .statOut(statOut), .frameStart(frameStart)
  );

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: {frameStart,statOut} got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] dipNext(logic [1:0] a, logic [1:0] w);
    return {a[0], a[1]} ^ w;
  endfunction

  function automatic int effLen(int l);
    if (l == 0) return 1;
    if (l > MAX_LEN) return MAX_LEN;
    return l;
  endfunction

  function automatic int effRep(int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic randomCfg();
    calReq       = 1'($urandom_range(0, 1));
    selInsertEn  = 1'($urandom_range(0, 1));
    dipCoversSel = 1'($urandom_range(0, 1));
    cal0Len      = LEN_W'($urandom_range(0, (1 << LEN_W) - 1));
    cal1Len      = LEN_W'($urandom_range(0, (1 << LEN_W) - 1));
    cal0Rep      = REP_W'($urandom_range(0, (1 << REP_W) - 1));
    cal1Rep      = REP_W'($urandom_range(0, (1 << REP_W) - 1));
  endtask

  // Waits for a frame, snapshots configuration at its framing word and
  // compares every word. mutate: scramble config mid-frame (R6).
  // dropEn: clear enable as the frame starts (R10).
  task automatic checkFrame(string scen, bit mutate, bit dropEn);
    int guard = 0;
    bit ins, cal, cov;
    int len, rp;
    logic [1:0] acc, sel, s;
    while (frameStart !== 1'b1) begin
      @(negedge clk);
      guard++;
      if (guard > 200) begin
        check({scen, " R1 frame never started"}, 3'b000, 3'b111);
        return;
      end
    end
    check({scen, " R1"}, {frameStart, statOut}, 3'b111);
    ins = selInsertEn;
    cal = selInsertEn & calReq;  // R4: no insertion forces calendar 0
    cov = dipCoversSel;
    len = effLen(cal ? int'(cal1Len) : int'(cal0Len));
    rp  = effRep(cal ? int'(cal1Rep) : int'(cal0Rep));
    acc = 2'b00;
    if (dropEn) enable = 1'b0;
    if (mutate) randomCfg();
    if (ins) begin
      sel = cal ? 2'b10 : 2'b01;
      if (cov) acc = dipNext(acc, sel);  // R9
      @(negedge clk);
      check({scen, " R2 R3 sel word"}, {frameStart, statOut}, {1'b0, sel});
      if (mutate) randomCfg();
    end
    for (int r = 0; r < rp; r++) begin
      for (int i = 0; i < len; i++) begin
        s = cal ? tbl1[i] : tbl0[i];
        if (s == 2'b11) s = 2'b10;  // R7
        acc = dipNext(acc, s);
        @(negedge clk);
        check({scen, " R5 R7 entry"}, {frameStart, statOut}, {1'b0, s});
        if (mutate) randomCfg();
      end
    end
    @(negedge clk);
    check({scen, " R8 R9 parity"}, {frameStart, statOut}, {1'b0, ~acc});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rstN = 1'b0; enable = 1'b0; selInsertEn = 1'b0; calReq = 1'b0;
    dipCoversSel = 1'b0; cal0Len = 4; cal1Len = 4; cal0Rep = 1; cal1Rep = 1;
    for (int i = 0; i < MAX_LEN; i++) begin
      tbl0[i] = 2'($urandom_range(0, 3));
      tbl1[i] = 2'($urandom_range(0, 3));
    end
    tbl0[0] = 2'b11; tbl1[1] = 2'b11;

    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 during reset", {frameStart, statOut}, 3'b011);
    rstN = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R10 idle before enable", {frameStart, statOut}, 3'b011);
    end

    // R4: insertion off, calendar 1 requested but calendar 0 used
    calReq = 1'b1; cal0Len = 5; cal1Len = 3; cal0Rep = 2;
    enable = 1'b1;
    checkFrame("R4 R10 start", 1'b0, 1'b0);
    checkFrame("R4", 1'b0, 1'b0);

    // R2 R3 R9: calendar 1 with and without parity coverage
    selInsertEn = 1'b1; dipCoversSel = 1'b1; cal1Len = 6; cal1Rep = 1;
    checkFrame("sel-frame", 1'b0, 1'b0);  // boundary: new config takes effect next frame
    checkFrame("R9 covered cal1", 1'b0, 1'b0);
    dipCoversSel = 1'b0;
    checkFrame("sel-frame", 1'b0, 1'b0);
    checkFrame("R9 excluded cal1", 1'b0, 1'b0);
    calReq = 1'b0;
    checkFrame("sel-frame", 1'b0, 1'b0);
    checkFrame("R3 cal0", 1'b0, 1'b0);

    // R5: clamp and zero cases
    cal0Len = 0; cal0Rep = 0;
    checkFrame("len-frame", 1'b0, 1'b0);
    checkFrame("R5 zero len rep", 1'b0, 1'b0);
    cal0Len = LEN_W'(MAX_LEN + 5); cal0Rep = 3;
    checkFrame("len-frame", 1'b0, 1'b0);
    checkFrame("R5 clamp len", 1'b0, 1'b0);

    // R7: every slot returns '11'
    @(negedge clk);
    while (frameStart !== 1'b1) @(negedge clk);
    enable = 1'b0;
    while (frameStart === 1'b1 || statOut !== 2'b11 || slotIdx != '0) @(negedge clk);
    repeat (40) @(negedge clk);
    for (int i = 0; i < MAX_LEN; i++) tbl0[i] = 2'b11;
    calReq = 1'b0; selInsertEn = 1'b1; dipCoversSel = 1'b1; cal0Len = 8; cal0Rep = 1;
    enable = 1'b1;
    checkFrame("R7 all reserved", 1'b0, 1'b0);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    for (int i = 0; i < MAX_LEN; i++) tbl0[i] = 2'($urandom_range(0, 3));
    enable = 1'b1;

    // R6: random configuration, scrambled during each frame
    for (int f = 0; f < 120; f++) checkFrame("R6 random", 1'b1, 1'b0);

    // R10: drop enable at frame start; frame completes, then idle framing
    checkFrame("R10 drop enable", 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R10 idle after drop", {frameStart, statOut}, 3'b011);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule